// File: doc/BRIEF.md
# Wake Event Source and Mask Registers

This block is the small register pair that sits between a bus controller's event detectors and a microcontroller's wake and interrupt logic. Two pulse inputs, one for a bus reset and one for a bus resume, set sticky flags in an event register. A third flag in that register is not stored. It shows, live, whether either of two external interrupt request lines is high.

A second register holds one enable-blocking bit per event, and it comes out of reset with every event blocked. Every flag that is set and not blocked is ORed into an interrupt line for the CPU's external interrupt input. The same flags are also ORed into a separate wake request line, which restarts a stopped CPU clock and its oscillators.

Software reaches both registers through a flat address, write-data and write-strobe bus with a combinational read port. Software clears a sticky flag by writing a one to it.

Top module: `wake_event_regs`

## Requirements
- R1: The event register decodes at address 0xA0 and the mask register at 0xA6. Any other address reads 0x00, and a write to it changes nothing.
- R2: A synchronous active-high reset sets the event register to 0x00 and the mask register to 0xFF.
- R3: A one-cycle pulse on `evt_bus_reset` sets event bit 2, and a pulse on `evt_resume` sets event bit 1. Each bit stays set until software clears it.
- R4: Writing 0xA0 with a 1 in bit 2 or bit 1 clears that event bit at the next clock. A 0 in that position leaves the bit unchanged.
- R5: Event bit 0 is read-only. It always reads as `req_ata | req_gpio` in the same cycle, and writes to it have no effect.
- R6: If a set pulse and a write-one clear hit the same event bit in the same cycle, the bit ends up set.
- R7: Bits 7..3 are reserved. In the event register they read 0, in the mask register they read 1, and writes to them are ignored.
- R8: Mask bits 2..0 are writable at 0xA6. A mask bit of 0 enables the matching event and a mask bit of 1 blocks it.
- R9: `irq_out` is high in the same cycle whenever any event bit is 1 while its mask bit is 0, and low otherwise.
- R10: `wake_req` follows the same enabled-event OR as `irq_out`, with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| evt_bus_reset | input | 1 | Bus reset detected pulse |
| evt_resume | input | 1 | Bus resume detected pulse |
| req_ata | input | 1 | Storage interrupt request level |
| req_gpio | input | 1 | GPIO interrupt request level |
| irq_out | output | 1 | Enabled-event interrupt to the CPU |
| wake_req | output | 1 | Enabled-event request to restart clocks |

## Verification
The bench fires a set pulse into the same cycle as a write-one clear of that bit. A design that lets the clear win would lose the event and never raise `irq_out`. It writes zeros and ones to the live bit and to the reserved fields. This catches designs that latch bit 0, that read the reserved mask bits as 0, or that decode a near-miss address. It also moves the mask while events are pending and checks `irq_out` and `wake_req` in that same cycle. A design that registered the outputs, or that read mask polarity the wrong way round, would be one cycle late or fire on blocked events.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned EVT_EXT = 0;
  localparam int unsigned EVT_RSM = 1;
  localparam int unsigned EVT_RST = 2;
  localparam int unsigned EVT_CNT = 3;
endpackage

// File: rtl/wake_src_reg.sv
module wake_src_reg #(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_we,
  input  logic [NUM_EVT-1:0] clr_mask,
  input  logic [NUM_EVT-1:0] set_pulse,
  input  logic               live_lvl,
  output logic [NUM_EVT-1:0] src_bits
);
  // Bit 0 is a live level; bits above it are sticky flags.
  assign src_bits[0] = live_lvl;

  logic unused_set0;
  assign unused_set0 = set_pulse[0] ^ clr_mask[0];

  for (genvar g = 1; g < NUM_EVT; g++) begin : g_sticky
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst)
        flag_q <= 1'b0;
      else if (set_pulse[g])
        flag_q <= 1'b1;              // set has priority over clear
      else if (clr_we && clr_mask[g])
        flag_q <= 1'b0;
    end
    assign src_bits[g] = flag_q;
  end
endmodule

// File: rtl/wake_mask_reg.sv
module wake_mask_reg #(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_EVT-1:0] wdata,
  output logic [NUM_EVT-1:0] msk_bits
);
  always_ff @(posedge clk) begin
    if (rst)
      msk_bits <= '1;
    else if (we)
      msk_bits <= wdata;
  end
endmodule

// File: rtl/wake_irq_merge.sv
module wake_irq_merge #(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic [NUM_EVT-1:0] src_bits,
  input  logic [NUM_EVT-1:0] msk_bits,
  output logic               irq_out,
  output logic               wake_req
);
  logic [NUM_EVT-1:0] enabled;
  assign enabled  = src_bits & ~msk_bits;
  assign irq_out  = |enabled;
  assign wake_req = |enabled;
endmodule

// File: rtl/wake_event_regs.sv
module wake_event_regs #(
  parameter int unsigned   ADDR_W   = 8,
  parameter int unsigned   DATA_W   = 8,
  parameter logic [7:0]    SRC_ADDR = 8'hA0,
  parameter logic [7:0]    MSK_ADDR = 8'hA6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_bus_reset,
  input  logic              evt_resume,
  input  logic              req_ata,
  input  logic              req_gpio,
  output logic              irq_out,
  output logic              wake_req
);
  import wake_pkg::*;
  localparam int unsigned NUM_EVT = EVT_CNT;
  localparam int unsigned RSV_W   = DATA_W - NUM_EVT;

  logic               hit_src, hit_msk;
  logic [NUM_EVT-1:0] src_bits, msk_bits, set_pulse;
  logic               unused_wdata;

  assign hit_src      = (bus_addr == ADDR_W'(SRC_ADDR));
  assign hit_msk      = (bus_addr == ADDR_W'(MSK_ADDR));
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_EVT];

  always_comb begin
    set_pulse          = '0;
    set_pulse[EVT_RST] = evt_bus_reset;
    set_pulse[EVT_RSM] = evt_resume;
  end

  wake_src_reg #(.NUM_EVT(NUM_EVT)) i_src (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (bus_we && hit_src),
    .clr_mask (bus_wdata[NUM_EVT-1:0]),
    .set_pulse(set_pulse),
    .live_lvl (req_ata | req_gpio),
    .src_bits (src_bits)
  );

  wake_mask_reg #(.NUM_EVT(NUM_EVT)) i_msk (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we && hit_msk),
    .wdata   (bus_wdata[NUM_EVT-1:0]),
    .msk_bits(msk_bits)
  );

  wake_irq_merge #(.NUM_EVT(NUM_EVT)) i_merge (
    .src_bits(src_bits),
    .msk_bits(msk_bits),
    .irq_out (irq_out),
    .wake_req(wake_req)
  );

  always_comb begin
    if (hit_src)
      bus_rdata = {{RSV_W{1'b0}}, src_bits};
    else if (hit_msk)
      bus_rdata = {{RSV_W{1'b1}}, msk_bits};
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/wake_event_chk.sv
module wake_event_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  SRC_ADDR = 8'hA0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              evt_bus_reset,
  input logic              evt_resume,
  input logic              req_ata,
  input logic              req_gpio,
  input logic [2:0]        src_bits,
  input logic [2:0]        msk_bits,
  input logic              irq_out,
  input logic              wake_req
);
  logic clr_hit;
  assign clr_hit = bus_we && (bus_addr == ADDR_W'(SRC_ADDR));

  assert_reset_state_R2: assert property (@(posedge clk)
    $past(rst) |-> (src_bits[2:1] == 2'b00 && msk_bits == 3'b111));

  assert_set_rst_R3: assert property (@(posedge clk) disable iff (rst)
    evt_bus_reset |=> src_bits[2]);

  assert_set_rsm_R3: assert property (@(posedge clk) disable iff (rst)
    evt_resume |=> src_bits[1]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && bus_wdata[2] && !evt_bus_reset) |=> !src_bits[2]);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (src_bits[1] && !(clr_hit && bus_wdata[1])) |=> src_bits[1]);

  assert_live_R5: assert property (@(posedge clk) disable iff (rst)
    (!msk_bits[0] && (req_ata || req_gpio)) |-> irq_out);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && bus_wdata[2] && evt_bus_reset) |=> src_bits[2]);

  assert_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (msk_bits == 3'b111) |-> !irq_out);

  assert_wake_R10: assert property (@(posedge clk) disable iff (rst)
    wake_req == irq_out);
endmodule

bind wake_event_regs wake_event_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_ADDR(SRC_ADDR)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_we       (bus_we),
  .evt_bus_reset(evt_bus_reset),
  .evt_resume   (evt_resume),
  .req_ata      (req_ata),
  .req_gpio     (req_gpio),
  .src_bits     (src_bits),
  .msk_bits     (msk_bits),
  .irq_out      (irq_out),
  .wake_req     (wake_req)
);

// File: tb/test_wake_event_regs.sv
module test_wake_event_regs;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_we, evt_bus_reset, evt_resume, req_ata, req_gpio;
  logic       irq_out, wake_req;

  int checks = 0;
  int errors = 0;
  // reference model state
  int m_s2 = 0, m_s1 = 0, m_msk = 7;

  always #2 clk = ~clk;

  wake_event_regs i_wake_event_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .evt_bus_reset(evt_bus_reset),
    .evt_resume(evt_resume), .req_ata(req_ata), .req_gpio(req_gpio),
    .irq_out(irq_out), .wake_req(wake_req)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, compare against the model, then update the model.
  task automatic step(string tag, bit r, int a, bit we, int wd,
                      bit er, bit es, bit ata, bit gp);
    int live, exp_rd, en;
    @(negedge clk);
    rst = r; bus_addr = 8'(a); bus_we = we; bus_wdata = 8'(wd);
    evt_bus_reset = er; evt_resume = es; req_ata = ata; req_gpio = gp;
    #1;
    live = (ata || gp) ? 1 : 0;
    if (a == 'hA0)      exp_rd = m_s2 * 4 + m_s1 * 2 + live;
    else if (a == 'hA6) exp_rd = 'hF8 + m_msk;
    else                exp_rd = 0;
    en = (m_s2 * 4 + m_s1 * 2 + live) & ~m_msk & 7;
    if (!r) begin
      check(tag, "rdata", int'(bus_rdata), exp_rd);
      check("R9", "irq_out", int'(irq_out), en != 0);
      check("R10", "wake_req", int'(wake_req), en != 0);
    end
    @(posedge clk);
    if (r) begin
      m_s2 = 0; m_s1 = 0; m_msk = 7;
    end else begin
      if (er) m_s2 = 1; else if (we && a == 'hA0 && wd[2]) m_s2 = 0;
      if (es) m_s1 = 1; else if (we && a == 'hA0 && wd[1]) m_s1 = 0;
      if (we && a == 'hA6) m_msk = wd & 7;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; bus_addr = 0; bus_wdata = 0; bus_we = 0;
    evt_bus_reset = 0; evt_resume = 0; req_ata = 0; req_gpio = 0;
    step("R2", 1, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 'hA6, 0, 0, 0, 0, 0, 0);
    // R3: resume pulse sets bit 1, mask still blocks (R8)
    step("R3", 0, 'hA0, 0, 0, 0, 1, 0, 0);
    step("R3", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    // R8/R7: enable bit 1 only, reserved written 0 read 1
    step("R8", 0, 'hA6, 1, 'h05, 0, 0, 0, 0);
    step("R7", 0, 'hA6, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    // R4: zero write leaves bit, one write clears it
    step("R4", 0, 'hA0, 1, 'h00, 0, 0, 0, 0);
    step("R4", 0, 'hA0, 1, 'h02, 0, 0, 0, 0);
    step("R4", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    // R6: set and clear in same cycle, set wins
    step("R6", 0, 'hA0, 1, 'h06, 1, 1, 0, 0);
    step("R6", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 'hA6, 1, 'h03, 0, 0, 0, 0);
    step("R9", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 'hA0, 1, 'h06, 0, 0, 0, 0);
    // R5: live bit 0 from each request, writes ignored
    step("R5", 0, 'hA0, 0, 0, 0, 0, 1, 0);
    step("R5", 0, 'hA0, 1, 'h01, 0, 0, 1, 0);
    step("R5", 0, 'hA6, 1, 'h06, 0, 0, 0, 1);
    step("R5", 0, 'hA0, 0, 0, 0, 0, 0, 1);
    step("R5", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 'hA0, 0, 0, 0, 0, 1, 1);
    // R1: near-miss addresses ignored and read 0
    step("R1", 0, 'hA3, 1, 'hFF, 0, 0, 0, 0);
    step("R1", 0, 'hA7, 1, 'h00, 0, 0, 0, 0);
    step("R1", 0, 'hA6, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 'h20, 0, 0, 0, 0, 0, 0);
    // R7: reserved event bits ignore writes, read 0
    step("R7", 0, 'hA0, 1, 'hF8, 0, 1, 0, 0);
    step("R7", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 'hA6, 1, 'h07, 0, 0, 0, 0);
    step("R10", 0, 'hA0, 0, 0, 0, 0, 1, 0);
    // reset again mid-run
    step("R2", 1, 'hA0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 'hA6, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 'hA0, 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule